// File: doc/BRIEF.md
# Zero-Test Branch Resolution Unit

This unit holds the program counter and resolves, each cycle, where it goes next. A branch code, a register value to test and a 10-bit signed PC-relative offset come in. The unit reports the next address and whether the branch is taken. The target is measured from the address of the following instruction, so the target is the current PC plus one plus the sign-extended offset. The sum wraps modulo the PC width.

Conditional branches compare the tested value against zero as a signed number. A branch whose condition fails behaves as a plain instruction: the PC steps by one. The PC register takes the resolved address on a clock edge only while the enable input is high. Instruction decode, register-file reads and pipeline flushing are left to the surrounding core.

Top module: `branchUnit`

## Requirements
- R1: While the active-low reset `rstN` is low, `pc` is 0.
- R2: On a rising clock edge with `en` high, `pc` takes the value `nextPc` had before the edge. With `en` low, `pc` keeps its value.
- R3: Branch code 0 (no branch) and the unused codes 6 and 7 give `taken` = 0 and `nextPc` = `pc` + 1.
- R4: Branch code 1 (unconditional) always gives `taken` = 1 and `nextPc` = target.
- R5: The target is `pc` + 1 + the offset. The offset is read as a 10-bit two's-complement number and sign-extended to 16 bits. For example, `pc` = 620 with offset 10'b1110100101 (-91) gives 530.
- R6: Branch code 2 is taken exactly when `testVal` equals 0.
- R7: Branch code 3 is taken exactly when `testVal` is not 0.
- R8: Branch code 4 is taken exactly when `testVal`, read as signed, is below 0 (bit 15 set).
- R9: Branch code 5 is taken exactly when `testVal`, read as signed, is at most 0.
- R10: A conditional branch whose condition fails gives `taken` = 0 and `nextPc` = `pc` + 1.
- R11: Both the sequential step and the target addition wrap modulo 2^16. From `pc` = 16'hFFFF the sequential step gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Update enable for the PC register |
| brType | input | 3 | Branch code: 0 none, 1 always, 2 zero, 3 nonzero, 4 negative, 5 nonpositive |
| testVal | input | 16 | Register value tested against zero |
| offset | input | 10 | Signed PC-relative displacement |
| pc | output | 16 | Current program counter |
| nextPc | output | 16 | Resolved next address |
| taken | output | 1 | Branch taken |

## Verification
Every branch code is swept against tested values that sit on the zero boundary: zero, plus and minus one, and the largest positive and negative values. This exposes a condition that mixes up signed and unsigned, or strict and non-strict, comparison. The unconditional code is run through all 1024 offsets at three PC values, 0, 620 and 16'hFFFF, so that sign extension, the plus-one base and wraparound are each separated. Enable-low cycles show the register holding, and the worked 620-to-530 branch is checked directly.

// File: rtl/branch_pkg.sv
package branch_pkg;

  typedef enum logic [2:0] {
    BR_NONE   = 3'd0,
    BR_ALWAYS = 3'd1,
    BR_EQZ    = 3'd2,
    BR_NEZ    = 3'd3,
    BR_LTZ    = 3'd4,
    BR_LEZ    = 3'd5,
    BR_RSV6   = 3'd6,
    BR_RSV7   = 3'd7
  } brCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;     // select target instead of sequential address
    logic isBranch; // a recognised branch code is present
  } ctrlStrobes_t;

endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        brType,
  input  logic [DATA_W-1:0] testVal,
  output ctrlStrobes_t      strobes
);

  localparam int SIGN_BIT = DATA_W - 1;

  brCode_e code;
  logic    isZero;
  logic    isNeg;
  logic    condMet;

  assign code   = brCode_e'(brType);
  assign isZero = (testVal == '0);
  assign isNeg  = testVal[SIGN_BIT];

  always_comb begin
    condMet          = 1'b0;
    strobes.isBranch = 1'b1;
    unique case (code)
      BR_ALWAYS: condMet = 1'b1;
      BR_EQZ:    condMet = isZero;
      BR_NEZ:    condMet = !isZero;
      BR_LTZ:    condMet = isNeg;
      BR_LEZ:    condMet = isNeg || isZero;
      default: begin
        condMet          = 1'b0;
        strobes.isBranch = 1'b0;
      end
    endcase
    strobes.take = strobes.isBranch && condMet;
  end

  // R4
  always_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brType == BR_ALWAYS) |-> strobes.take);

  // R3
  none_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brType == BR_NONE || brType == BR_RSV6 || brType == BR_RSV7) |-> !strobes.take);

  // R6
  eqz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brType == BR_EQZ && testVal != '0) |-> !strobes.take);

  // R7
  nez_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brType == BR_NEZ && testVal == '0) |-> !strobes.take);

  // R8
  ltz_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brType == BR_LTZ && $signed(testVal) >= 0) |-> !strobes.take);

  // R9
  lez_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brType == BR_LEZ && $signed(testVal) > 0) |-> !strobes.take);

endmodule

// File: rtl/branch_dp.sv
module branch_dp
  import branch_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  ctrlStrobes_t     strobes,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  pc,
  output logic [PC_W-1:0]  nextPc
);

  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] seqPc;
  logic [PC_W-1:0] offExt;
  logic [PC_W-1:0] target;

  generate
    if (EXT_W > 0) begin : g_sext
      assign offExt = {{EXT_W{offset[OFF_W-1]}}, offset};
    end else begin : g_trunc
      assign offExt = offset[PC_W-1:0];
    end
  endgenerate

  assign seqPc  = pc + PC_W'(1);
  assign target = seqPc + offExt;
  assign nextPc = strobes.take ? target : seqPc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   pc <= '0;
    else if (en) pc <= nextPc;
  end

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(pc));

  // R2
  pc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    en |=> (pc == $past(nextPc)));

  // R10
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.take |-> (PC_W'(nextPc - pc) == PC_W'(1)));

  // R5
  target_dist_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |-> (PC_W'(nextPc - pc - PC_W'(1)) == offExt));

endmodule

// File: rtl/branchUnit.sv
module branchUnit
  import branch_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 16,
  parameter int OFF_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [2:0]        brType,
  input  logic [DATA_W-1:0] testVal,
  input  logic [OFF_W-1:0]  offset,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken
);

  ctrlStrobes_t strobes;

  branch_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .brType  (brType),
    .testVal (testVal),
    .strobes (strobes)
  );

  branch_dp #(.PC_W(PC_W), .OFF_W(OFF_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .en      (en),
    .strobes (strobes),
    .offset  (offset),
    .pc      (pc),
    .nextPc  (nextPc)
  );

  assign taken = strobes.take;

  // R1
  reset_pc_chk: assert property (@(posedge clk) !rstN |-> (pc == '0));

endmodule

// File: tb/tb_branchUnit.sv
module tb_branchUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  brType = 3'd0;
  logic [15:0] testVal = 16'd0;
  logic [9:0]  offset = 10'd0;
  logic [15:0] pc, nextPc;
  logic        taken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  branchUnit dut (
    .clk(clk), .rstN(rstN), .en(en), .brType(brType), .testVal(testVal),
    .offset(offset), .pc(pc), .nextPc(nextPc), .taken(taken)
  );

  always #4 clk = ~clk;

  function automatic bit expTaken(input logic [2:0] t, input logic [15:0] v);
    case (t)
      3'd1: return 1'b1;
      3'd2: return v == 16'd0;
      3'd3: return v != 16'd0;
      3'd4: return $signed(v) < 0;
      3'd5: return $signed(v) <= 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] expNext(input logic [15:0] p, input bit tk,
                                          input logic [9:0] o);
    int s;
    s = int'(p) + 1 + (tk ? int'($signed(o)) : 0);
    return 16'(s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs with en low, compare combinational outputs against the model
  task automatic combCheck(input string req, input logic [2:0] t,
                           input logic [15:0] v, input logic [9:0] o);
    bit tk;
    @(negedge clk);
    brType = t; testVal = v; offset = o; en = 1'b0;
    #1;
    tk = expTaken(t, v);
    check(req, {31'd0, taken}, {31'd0, tk});
    check(req, {16'd0, nextPc}, {16'd0, expNext(pc, tk, o)});
  endtask

  task automatic jump(input logic [9:0] o);
    @(negedge clk);
    brType = 3'd1; offset = o; en = 1'b1;
    @(negedge clk);
    en = 1'b0; brType = 3'd0;
  endtask

  task automatic sweep(input string tag);
    logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0005};
    for (int t = 0; t < 8; t++)
      for (int k = 0; k < 6; k++)
        combCheck(tag, 3'(t), vals[k], 10'h3F0);
    for (int o = 0; o < 1024; o++)
      combCheck("R4 R5 full offset", 3'd1, 16'd0, 10'(o));
  endtask

  initial begin
    logic [15:0] held;
    #20;
    check("R1 reset pc", {16'd0, pc}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // condition sweep at pc 0: R3 R6 R7 R8 R9 R10
    sweep("R3 R6 R7 R8 R9 R10 sweep pc0");

    // R2: en low holds
    @(negedge clk); brType = 3'd1; offset = 10'd7; en = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R2 hold with en low", {16'd0, pc}, 32'd0);

    // R2: reach 620 with two jumps: 0 -> 512 -> 620
    jump(10'd511);
    check("R2 load 512", {16'd0, pc}, 32'd512);
    jump(10'd107);
    check("R2 load 620", {16'd0, pc}, 32'd620);

    // R5 worked example
    combCheck("R5 620 to 530", 3'd1, 16'd0, 10'b1110100101);
    check("R5 example value", {16'd0, nextPc}, 32'd530);
    sweep("R6 R7 R8 R9 R10 sweep pc620");

    // R11: 620 -> 0 (offset -621 out of range; go 620 -> 109 -> 0 -> FFFF)
    jump(10'(-512));
    check("R2 load 109", {16'd0, pc}, 32'd109);
    jump(10'(-110));
    check("R2 load 0", {16'd0, pc}, 32'd0);
    jump(10'(-2));
    check("R11 wrap to FFFF", {16'd0, pc}, 32'hFFFF);
    combCheck("R11 seq wrap", 3'd0, 16'd0, 10'd0);
    check("R11 seq value", {16'd0, nextPc}, 32'd0);
    sweep("R11 sweep pcFFFF");

    // R2: step with condition false
    held = pc;
    @(negedge clk); brType = 3'd2; testVal = 16'd3; offset = 10'd50; en = 1'b1;
    @(negedge clk); en = 1'b0;
    check("R10 not taken advances", {16'd0, pc}, {16'd0, 16'(held + 16'd1)});

    // R1: reset again mid-run
    @(negedge clk); rstN = 1'b0; #1;
    check("R1 async reset", {16'd0, pc}, 32'd0);
    @(negedge clk); rstN = 1'b1;

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule